// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block sits at the write side of a parallel NOR flash device and turns bus write cycles into device behaviour. Each write carries a 16-bit word and an address. The low byte of the word is read as a command code. Some codes only change which source drives the read data: array contents, the status byte, identifier data or query data. Other codes open a two-write sequence that must be completed by a confirm write before an embedded operation is launched.

Operations are handed to a write-engine model through a one-cycle start pulse. The pulse comes with an operation kind, a latched address and a latched data word. The engine reports back through a busy level and two error pulses. While an operation runs, the block filters incoming commands. It also switches the read path to status on its own, and it keeps a sticky error field that only an explicit clear command removes. The status byte seen on the read path is a snapshot, and a new snapshot is taken on every read strobe.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, rd_mode is 0 (array), dout equals arr_data, op_start is low and both error bits are clear.
- R2: With no operation running, single-write codes select the read source. 0xFF selects rd_mode 0 (dout = arr_data), 0x70 selects 1 (dout = {8'h00, status snapshot}), 0x90 selects 2 (dout = id_data) and 0x98 selects 3 (dout = qry_data).
- R3: Outside a sequence, a code that has no meaning there (including a lone 0xD0) is ignored, and rd_mode stays unchanged.
- R4: 0x40 followed by any write pulses op_start for one cycle. The pulse comes with op_kind 1, and op_addr/op_data hold the second write's address and data. rd_mode becomes 1 in the same cycle.
- R5: 0x20 followed by 0xD0 pulses op_start with op_kind 2 and op_addr equal to the confirm write's address.
- R6: 0x20 followed by any code other than 0xD0 starts nothing, sets status bits 5 and 4, and sets rd_mode to 1.
- R7: 0xE8 opens a buffered load. The next write's bits 8:0 give the word count minus one (1 to 512 words). Each of the following words pulses buf_load with its address and data on op_addr/op_data. A final 0xD0 starts op_kind 3; any other final code sets bits 5 and 4, starts nothing and sets rd_mode 1.
- R8: 0x80 followed by 0xD0 starts op_kind 4, and any other second code sets bits 5 and 4. While that operation runs, every write is forwarded as a buf_load pulse and is never decoded as a command.
- R9: While an operation is running (from its start until the engine drops busy), only 0x70 (sets rd_mode 1) and 0xB0 (pulses op_suspend) have an effect. All other writes are ignored, 0x50 included.
- R10: The status byte holds the engine ready flag in bit 7 (1 = idle), the erase/sequence error in bit 5 and the program/sequence error in bit 4; bits 6 and 3:0 are zero. It is sampled on each rd_strobe cycle and holds between strobes.
- R11: The engine error inputs set bit 4 (program) and bit 5 (erase). Error bits stay set through any other command and are cleared only by 0x50 issued while idle.
- R12: Once status is selected, rd_mode stays 1 until a 0xFF, 0x90 or 0x98 command is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write cycle strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; low byte is the command code |
| rd_strobe | input | 1 | Read cycle strobe; refreshes the status snapshot |
| arr_data | input | DW | Array read data |
| id_data | input | DW | Identifier read data |
| qry_data | input | DW | Query read data |
| eng_busy | input | 1 | Write engine busy |
| eng_prog_err | input | 1 | Engine program error pulse |
| eng_erase_err | input | 1 | Engine erase error pulse |
| op_start | output | 1 | One-cycle operation launch |
| op_kind | output | 3 | Operation kind: 1 program, 2 erase, 3 buffered, 4 blank-array |
| op_addr | output | AW | Latched address for launch or buffer load |
| op_data | output | DW | Latched data for launch or buffer load |
| buf_load | output | 1 | One-cycle buffer word strobe |
| op_suspend | output | 1 | One-cycle suspend request |
| rd_mode | output | 2 | Active read source |
| dout | output | DW | Read data |

## Verification
The bench targets the sequence corners. A setup code followed by a wrong confirm must raise both error bits and launch nothing; a design that launches anyway or leaves the read path unchanged gets caught. Commands written during a busy operation are tested so that a clear or a read-array command is seen to be ignored; a design that obeys them would lose sticky errors or drop out of status. The blank-array run is exercised so that a suspend code is shown to be forwarded as data and not acted on. The buffered load is driven with an exact word count so that an off-by-one in the counter shifts the confirm point.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
    typedef enum logic [1:0] {RM_ARRAY = 2'd0, RM_STATUS = 2'd1, RM_IDENT = 2'd2, RM_QUERY = 2'd3} rmode_e;
    typedef enum logic [2:0] {OP_NONE = 3'd0, OP_PROG = 3'd1, OP_ERASE = 3'd2, OP_BUF = 3'd3, OP_BLANK = 3'd4} opk_e;
    typedef enum logic [3:0] {
        C_RD_ARRAY, C_RD_STAT, C_RD_ID, C_RD_QRY, C_CLR, C_PROG, C_ERASE,
        C_BUF, C_BLANK, C_CONFIRM, C_SUSP, C_OTHER
    } cmd_e;
    typedef enum logic [2:0] {S_IDLE, S_PROG, S_ERASE, S_BLANK, S_BCNT, S_BLOAD, S_BCONF} st_e;

    localparam logic [7:0] K_RD_ARRAY = 8'hFF;
    localparam logic [7:0] K_RD_STAT  = 8'h70;
    localparam logic [7:0] K_RD_ID    = 8'h90;
    localparam logic [7:0] K_RD_QRY   = 8'h98;
    localparam logic [7:0] K_CLR      = 8'h50;
    localparam logic [7:0] K_PROG     = 8'h40;
    localparam logic [7:0] K_ERASE    = 8'h20;
    localparam logic [7:0] K_BUF      = 8'hE8;
    localparam logic [7:0] K_BLANK    = 8'h80;
    localparam logic [7:0] K_CONFIRM  = 8'hD0;
    localparam logic [7:0] K_SUSP     = 8'hB0;
endpackage

// File: rtl/flash_cmd_decode.sv
module flash_cmd_decode
    import flash_cmd_pkg::*;
(
    input  logic [7:0] code,
    output cmd_e       cmd
);
    always_comb begin
        case (code)
            K_RD_ARRAY: cmd = C_RD_ARRAY;
            K_RD_STAT:  cmd = C_RD_STAT;
            K_RD_ID:    cmd = C_RD_ID;
            K_RD_QRY:   cmd = C_RD_QRY;
            K_CLR:      cmd = C_CLR;
            K_PROG:     cmd = C_PROG;
            K_ERASE:    cmd = C_ERASE;
            K_BUF:      cmd = C_BUF;
            K_BLANK:    cmd = C_BLANK;
            K_CONFIRM:  cmd = C_CONFIRM;
            K_SUSP:     cmd = C_SUSP;
            default:    cmd = C_OTHER;
        endcase
    end
endmodule

// File: rtl/flash_status_reg.sv
module flash_status_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_seq,
    input  logic       set_prog,
    input  logic       set_erase,
    input  logic       clr,
    input  logic       rdy,
    input  logic       rd_strobe,
    output logic [1:0] err,
    output logic [7:0] snap
);
    typedef struct packed {
        logic [1:0] err;
        logic [7:0] snap;
    } sr_t;

    sr_t sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (clr) sr_d.err = 2'b00;
        sr_d.err = sr_d.err | {set_erase | set_seq, set_prog | set_seq};
        if (rd_strobe) sr_d.snap = {rdy, 1'b0, sr_q.err[1], sr_q.err[0], 4'h0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign err  = sr_q.err;
    assign snap = sr_q.snap;
endmodule

// File: rtl/flash_rd_mux.sv
module flash_rd_mux
    import flash_cmd_pkg::*;
#(
    parameter int DW = 16
) (
    input  rmode_e        mode,
    input  logic [DW-1:0] arr_data,
    input  logic [DW-1:0] id_data,
    input  logic [DW-1:0] qry_data,
    input  logic [7:0]    snap,
    output logic [DW-1:0] dout
);
    localparam int PAD = DW - 8;

    always_comb begin
        case (mode)
            RM_ARRAY:  dout = arr_data;
            RM_STATUS: dout = {{PAD{1'b0}}, snap};
            RM_IDENT:  dout = id_data;
            default:   dout = qry_data;
        endcase
    end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int AW = 25,
    parameter int DW = 16,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_strobe,
    input  logic [DW-1:0] arr_data,
    input  logic [DW-1:0] id_data,
    input  logic [DW-1:0] qry_data,
    input  logic          eng_busy,
    input  logic          eng_prog_err,
    input  logic          eng_erase_err,
    output logic          op_start,
    output logic [2:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic          buf_load,
    output logic          op_suspend,
    output logic [1:0]    rd_mode,
    output logic [DW-1:0] dout
);
    localparam int NW = CW + 1;

    typedef struct packed {
        st_e           st;
        rmode_e        mode;
        logic          act;
        logic          seen;
        logic          blank;
        logic [NW-1:0] cnt;
        logic          start;
        opk_e          kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          load;
        logic          susp;
    } ctl_t;

    ctl_t q, d;
    cmd_e cmd;
    logic busy_any;
    logic set_seq, clr;
    logic [1:0] err_w;
    logic [7:0] snap_w;

    flash_cmd_decode u_dec (.code(wr_data[7:0]), .cmd(cmd));

    assign busy_any = q.act | eng_busy;

    always_comb begin
        d       = q;
        d.start = 1'b0;
        d.load  = 1'b0;
        d.susp  = 1'b0;
        set_seq = 1'b0;
        clr     = 1'b0;
        if (q.act) begin
            if (eng_busy) d.seen = 1'b1;
            else if (q.seen) begin
                d.act   = 1'b0;
                d.seen  = 1'b0;
                d.blank = 1'b0;
            end
        end
        if (wr_en) begin
            if (q.blank) begin
                d.load = 1'b1;
                d.addr = wr_addr;
                d.data = wr_data;
            end else if (busy_any) begin
                if (cmd == C_RD_STAT)  d.mode = RM_STATUS;
                else if (cmd == C_SUSP) d.susp = 1'b1;
            end else begin
                case (q.st)
                    S_IDLE: begin
                        case (cmd)
                            C_RD_ARRAY: d.mode = RM_ARRAY;
                            C_RD_STAT:  d.mode = RM_STATUS;
                            C_RD_ID:    d.mode = RM_IDENT;
                            C_RD_QRY:   d.mode = RM_QUERY;
                            C_CLR:      clr = 1'b1;
                            C_PROG:     d.st = S_PROG;
                            C_ERASE:    d.st = S_ERASE;
                            C_BUF:      d.st = S_BCNT;
                            C_BLANK:    d.st = S_BLANK;
                            default:    d.st = S_IDLE;
                        endcase
                    end
                    S_BCNT: begin
                        d.cnt = {1'b0, wr_data[CW-1:0]} + NW'(1);
                        d.st  = S_BLOAD;
                    end
                    S_BLOAD: begin
                        d.load = 1'b1;
                        d.addr = wr_addr;
                        d.data = wr_data;
                        d.cnt  = q.cnt - NW'(1);
                        if (q.cnt == NW'(1)) d.st = S_BCONF;
                    end
                    default: begin
                        d.st   = S_IDLE;
                        d.mode = RM_STATUS;
                        if (q.st == S_PROG || cmd == C_CONFIRM) begin
                            d.start = 1'b1;
                            d.act   = 1'b1;
                            d.seen  = 1'b0;
                            d.addr  = wr_addr;
                            d.data  = wr_data;
                            case (q.st)
                                S_PROG:  d.kind = OP_PROG;
                                S_ERASE: d.kind = OP_ERASE;
                                S_BLANK: d.kind = OP_BLANK;
                                default: d.kind = OP_BUF;
                            endcase
                            d.blank = (q.st == S_BLANK);
                        end else begin
                            set_seq = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_IDLE;
            q.mode <= RM_ARRAY;
            q.kind <= OP_NONE;
        end else begin
            q <= d;
        end
    end

    flash_status_reg u_sr (
        .clk(clk), .rst_n(rst_n), .set_seq(set_seq), .set_prog(eng_prog_err),
        .set_erase(eng_erase_err), .clr(clr), .rdy(~busy_any), .rd_strobe(rd_strobe),
        .err(err_w), .snap(snap_w)
    );

    flash_rd_mux #(.DW(DW)) u_mux (
        .mode(q.mode), .arr_data(arr_data), .id_data(id_data), .qry_data(qry_data),
        .snap(snap_w), .dout(dout)
    );

    assign op_start   = q.start;
    assign op_kind    = q.kind;
    assign op_addr    = q.addr;
    assign op_data    = q.data;
    assign buf_load   = q.load;
    assign op_suspend = q.susp;
    assign rd_mode    = q.mode;
endmodule

// File: rtl/flash_cmd_checker.sv
module flash_cmd_checker #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          busy_any,
    input logic          op_start,
    input logic          op_suspend,
    input logic [1:0]    rd_mode,
    input logic [1:0]    err,
    input logic          eng_erase_err,
    input logic [DW-1:0] dout
);
    p_no_start_when_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_any && wr_en) |=> !op_start);

    p_suspend_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        op_suspend |-> $past(busy_any));

    p_start_selects_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> (rd_mode == 2'd1));

    p_start_follows_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> $past(wr_en));

    p_clear_needs_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(err[0]) || $fell(err[1])) |->
            $past(wr_en && wr_data[7:0] == 8'h50 && !busy_any));

    p_seq_err_to_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(err[1]) && !$past(eng_erase_err)) |-> (rd_mode == 2'd1));

    p_status_format_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == 2'd1) |-> (dout[DW-1:8] == '0 && dout[6] == 1'b0 && dout[3:0] == 4'h0));
endmodule

bind flash_cmd_fsm flash_cmd_checker #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .busy_any(busy_any),
    .op_start(op_start), .op_suspend(op_suspend), .rd_mode(rd_mode), .err(err_w),
    .eng_erase_err(eng_erase_err), .dout(dout)
);

// File: tb/sim_flash_cmd_fsm.sv
module sim_flash_cmd_fsm;
    localparam int AW = 25;
    localparam int DW = 16;
    localparam logic [DW-1:0] ARR = 16'hA5A5;
    localparam logic [DW-1:0] IDV = 16'h1D1D;
    localparam logic [DW-1:0] QRY = 16'h5151;

    typedef struct packed {
        logic [15:0] code;
        logic [1:0]  mode;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{16'h00FF, 2'd0}, '{16'h0070, 2'd1}, '{16'h0090, 2'd2}, '{16'h0098, 2'd3},
        '{16'h0012, 2'd3}, '{16'h00FF, 2'd0}, '{16'h0050, 2'd0}, '{16'h0090, 2'd2},
        '{16'h00D0, 2'd2}, '{16'h0070, 2'd1}, '{16'h00FF, 2'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic rd_strobe = 1'b0;
    logic eng_busy, eng_prog_err, eng_erase_err;
    logic op_start, buf_load, op_suspend;
    logic [2:0] op_kind;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data, dout;
    logic [1:0] rd_mode;

    int checks = 0;
    int errors = 0;
    int loads = 0;
    int eng_cnt = 0;
    logic inj_prog = 1'b0;
    logic finished = 1'b0;

    always #2.5 clk = ~clk;

    assign eng_busy      = (eng_cnt != 0);
    assign eng_prog_err  = inj_prog && (eng_cnt == 1);
    assign eng_erase_err = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) eng_cnt <= 0;
        else if (op_start) eng_cnt <= 10;
        else if (eng_cnt != 0) eng_cnt <= eng_cnt - 1;
        if (buf_load) loads <= loads + 1;
    end

    flash_cmd_fsm #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_strobe(rd_strobe), .arr_data(ARR), .id_data(IDV), .qry_data(QRY),
        .eng_busy(eng_busy), .eng_prog_err(eng_prog_err), .eng_erase_err(eng_erase_err),
        .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
        .buf_load(buf_load), .op_suspend(op_suspend), .rd_mode(rd_mode), .dout(dout)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] data, input logic [AW-1:0] addr);
        @(negedge clk);
        wr_en = 1'b1; wr_data = data; wr_addr = addr;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic idle_wait();
        repeat (16) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_out(input logic [1:0] m);
        case (m)
            2'd0: return ARR;
            2'd2: return IDV;
            default: return QRY;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_mode == 2'd0, "R1 mode", rd_mode, 0);
        chk(dout == ARR, "R1 dout", dout, ARR);
        chk(op_start == 1'b0, "R1 start", op_start, 0);
        wr(16'h0070, '0); rd();
        chk(dout == 16'h0080, "R1 errors clear", dout, 16'h0080);

        // R2, R3, R12 table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i].code, '0);
            chk(rd_mode == VEC[i].mode, "R2/R3 table mode", rd_mode, VEC[i].mode);
            if (VEC[i].mode != 2'd1)
                chk(dout == exp_out(VEC[i].mode), "R2 table dout", dout, exp_out(VEC[i].mode));
            else
                chk(dout[15:8] == 8'h00, "R10 status upper", dout, 0);
        end

        // R4 program, R9 filtering
        wr(16'h0040, 25'h0000077);
        wr(16'hBEEF, 25'h0000123);
        chk(op_start == 1'b1, "R4 start", op_start, 1);
        chk(op_kind == 3'd1, "R4 kind", op_kind, 1);
        chk(op_addr == 25'h123 && op_data == 16'hBEEF, "R4 latch", op_data, 16'hBEEF);
        chk(rd_mode == 2'd1, "R4 mode", rd_mode, 1);
        rd();
        chk(dout == 16'h0000, "R10 busy status", dout, 0);
        wr(16'h00B0, '0);
        chk(op_suspend == 1'b1, "R9 suspend", op_suspend, 1);
        wr(16'h00FF, '0);
        chk(rd_mode == 2'd1, "R9 read array ignored", rd_mode, 1);
        idle_wait(); rd();
        chk(dout == 16'h0080, "R10 ready", dout, 16'h0080);
        rd();
        chk(dout == 16'h0080, "R10 snapshot held", dout, 16'h0080);

        // R5 erase
        wr(16'h0020, '0);
        wr(16'h00D0, 25'h0000040);
        chk(op_start && op_kind == 3'd2, "R5 start", op_kind, 2);
        chk(op_addr == 25'h40, "R5 addr", op_addr, 25'h40);
        idle_wait();

        // R6 bad erase sequence
        wr(16'h00FF, '0);
        wr(16'h0020, '0);
        wr(16'h00FF, '0);
        chk(op_start == 1'b0, "R6 no start", op_start, 0);
        chk(rd_mode == 2'd1, "R6 mode", rd_mode, 1);
        rd();
        chk(dout == 16'h00B0, "R6 bits", dout, 16'h00B0);

        // R9 clear ignored while busy, R11 clear when idle
        wr(16'h0040, '0); wr(16'h1234, 25'h5);
        wr(16'h0050, '0);
        idle_wait(); rd();
        chk(dout == 16'h00B0, "R9 clear ignored busy", dout, 16'h00B0);
        wr(16'h0050, '0); rd();
        chk(dout == 16'h0080, "R11 clear", dout, 16'h0080);

        // R11 engine error sticky
        inj_prog = 1'b1;
        wr(16'h0040, '0); wr(16'h0001, 25'h9);
        idle_wait();
        inj_prog = 1'b0;
        wr(16'h00FF, '0); wr(16'h0070, '0); rd();
        chk(dout == 16'h0090, "R11 sticky program error", dout, 16'h0090);
        wr(16'h0050, '0); rd();
        chk(dout == 16'h0080, "R11 cleared", dout, 16'h0080);

        // R7 buffered load of 3 words
        wr(16'h00FF, '0);
        wr(16'h00E8, 25'h200);
        wr(16'h0002, 25'h200);
        begin
            int l0 = loads;
            for (int k = 0; k < 3; k++) begin
                wr(16'hC000 + 16'(k), 25'h200 + 25'(k));
                chk(buf_load == 1'b1 && op_addr == 25'h200 + 25'(k), "R7 load", op_addr, 25'h200 + 25'(k));
            end
            wr(16'h00D0, 25'h200);
            chk(op_start && op_kind == 3'd3, "R7 start", op_kind, 3);
            chk(loads - l0 == 3, "R7 count", loads - l0, 3);
        end
        idle_wait();

        // R7 bad confirm
        wr(16'h00E8, 25'h300); wr(16'h0000, 25'h300); wr(16'h4444, 25'h300);
        wr(16'h0012, 25'h300);
        chk(op_start == 1'b0 && rd_mode == 2'd1, "R7 bad confirm", op_start, 0);
        rd();
        chk(dout == 16'h00B0, "R7 bits", dout, 16'h00B0);
        wr(16'h0050, '0);

        // R8 bad second code
        wr(16'h0080, '0); wr(16'h0040, '0);
        chk(op_start == 1'b0, "R8 bad no start", op_start, 0);
        rd();
        chk(dout == 16'h00B0, "R8 bits", dout, 16'h00B0);
        wr(16'h0050, '0);

        // R8 blank-array run
        wr(16'h0080, '0); wr(16'h00D0, 25'h10);
        chk(op_start && op_kind == 3'd4, "R8 start", op_kind, 4);
        wr(16'h00FF, 25'h11);
        chk(buf_load == 1'b1 && rd_mode == 2'd1, "R8 forwarded", buf_load, 1);
        wr(16'h00B0, 25'h12);
        chk(op_suspend == 1'b0 && buf_load == 1'b1, "R8 no suspend", op_suspend, 0);
        idle_wait();
        wr(16'h00FF, '0);
        chk(rd_mode == 2'd0, "R12 back to array", rd_mode, 0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule